// File: doc/BRIEF.md
# Read-Strobe Delay Pattern Tester

This block decides whether one candidate read-strobe delay setting captures memory data correctly. On a start pulse it latches the candidate delay word, a bias value and the memory size. It then walks a series of overlapping test regions spread across the memory. For each region it first puts a known-safe delay into the delay register. It fills the region with a filler word and rewrites every word with a pattern derived from that word's address. It then switches the delay register to the candidate and reads the region back, comparing each word against the pattern.

The first mismatch ends the test at once with a failure. If every region reads back cleanly, the block reports a pass. A calibration controller sits above it, chooses which delays to try and runs one test per candidate. That controller uses a bias of 3 while searching upward for the largest good delay and a bias of 1 while searching downward for the smallest. Memory traffic goes through a single-word request/acknowledge port. Delay updates go through a one-cycle write strobe.

Top module: `rdly_pattern_tester`

## Requirements
- R1: After reset, done, fail, mem_req and dly_we are all low.
- R2: Before the first memory access of each region, the block pulses dly_we for one cycle with the safe delay 0x00007474 (coarse 7, fine 4 in each 8-bit lane, coarse in the upper nibble).
- R3: Region start offsets are 0, S, 2S, ... with S = mem_size / 64 (integer division). A region is tested while its offset is below mem_size minus the region length (LINE_BYTES*LINES bytes). When mem_size is at most the region length, no region is tested. When S is zero, only the region at offset 0 is tested.
- R4: Every access is word aligned. Within a region, the byte address of word i is the region offset plus 4*i, and each of the three passes visits i in ascending order.
- R5: Under the safe delay, every word of the region is first written with 0x1F1F1F1F and then rewritten with its byte address plus i plus the bias, modulo 2^32.
- R6: After the pattern pass, the candidate word is written to the delay port. Only then is the region read back, and all reads of the region happen under the candidate delay.
- R7: The first read word that differs from its expected pattern ends the test: no further access or delay write follows, and done is raised with fail high.
- R8: If every tested region reads back correctly, done is raised with fail low.
- R9: done is high for exactly one cycle. fail is valid in that cycle, holds its value afterwards, and is cleared by the next accepted start.
- R10: A start pulse while a test is running is ignored; the latched candidate and bias stay in force.
- R11: Only one access is outstanding. mem_req and its address, write-enable and data stay stable until mem_ack, and dly_we is never raised while mem_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test; accepted only when idle |
| cand_dly | input | 32 | Candidate delay word, latched at start |
| bias | input | 32 | Pattern bias, latched at start |
| mem_size | input | ADDR_W | Memory size in bytes, latched at start |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Test result, 1 = mismatch seen |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| dly_we | output | 1 | Delay register write strobe |
| dly_wdata | output | 32 | Delay register value |

## Verification
The bench models a memory that corrupts one chosen word only when read under a non-safe delay. A design that wrote the pattern under the candidate delay, or read under the safe one, would therefore miss the fault or flag clean runs. Faults are placed in the first region, deep in the walk and past the last region, and the exact read count catches a design that keeps reading after a mismatch or stops one region early. A memory size equal to the region length and one whose stride rounds to zero probe the walk limits. An off-by-one or an underflow in the limit compare would test a phantom region or loop forever. A bias of all ones checks the 32-bit wrap, and a start pulse mid-run checks that the latched candidate is not overwritten.

// File: rtl/rdly_pkg.sv
package rdly_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = 4;

    localparam logic [WORD_W-1:0] FILL_WORD = 32'h1F1F_1F1F;

    localparam logic [3:0] SAFE_COARSE = 4'd7;
    localparam logic [3:0] SAFE_FINE   = 4'd4;
    localparam logic [WORD_W-1:0] SAFE_DLY =
        {16'h0000, SAFE_COARSE, SAFE_FINE, SAFE_COARSE, SAFE_FINE};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAFE,
        ST_FILL,
        ST_PATT,
        ST_CAND,
        ST_READ,
        ST_DONE
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] cand;
        logic [WORD_W-1:0] bias;
    } test_cfg_t;

    function automatic logic [WORD_W-1:0] pattern_word(
        input logic [WORD_W-1:0] addr,
        input logic [WORD_W-1:0] idx,
        input logic [WORD_W-1:0] bias
    );
        return addr + idx + bias;
    endfunction

endpackage

// File: rtl/rdly_region_walk.sv
module rdly_region_walk #(
    parameter int ADDR_W       = 32,
    parameter int REGION_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] size_i,
    output logic [ADDR_W-1:0] offset_o,
    output logic              none_o,
    output logic              last_o
);
    localparam int STRIDE_SHIFT = 6;
    localparam logic [ADDR_W:0] REGION_EXT = (ADDR_W+1)'(REGION_BYTES);

    logic [ADDR_W-1:0] size_q;
    logic [ADDR_W-1:0] offset_q;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W:0]   next_ext;
    logic [ADDR_W:0]   limit_ext;

    always_comb begin
        stride    = size_q >> STRIDE_SHIFT;
        next_ext  = {1'b0, offset_q} + {1'b0, stride};
        limit_ext = {1'b0, size_q} - REGION_EXT;
        none_o    = ({1'b0, size_q} <= REGION_EXT);
        last_o    = (stride == '0) || (next_ext >= limit_ext);
        offset_o  = offset_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q   <= '0;
            offset_q <= '0;
        end else if (load) begin
            size_q   <= size_i;
            offset_q <= '0;
        end else if (advance) begin
            offset_q <= next_ext[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/rdly_word_seq.sv
module rdly_word_seq #(
    parameter int WORDS = 1024,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic [IDX_W-1:0] idx_q;

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= last_o ? '0 : idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/rdly_pattern.sv
module rdly_pattern
    import rdly_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] bias_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] expect_o
);
    always_comb begin
        addr_o   = offset_i + ADDR_W'(idx_i) * ADDR_W'(WORD_BYTES);
        expect_o = pattern_word(WORD_W'(addr_o), WORD_W'(idx_i), bias_i);
    end
endmodule

// File: rtl/rdly_pattern_tester.sv
module rdly_pattern_tester
    import rdly_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int LINES      = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       cand_dly,
    input  logic [31:0]       bias,
    input  logic [ADDR_W-1:0] mem_size,
    output logic              done,
    output logic              fail,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              dly_we,
    output logic [31:0]       dly_wdata
);
    localparam int REGION_BYTES = LINE_BYTES * LINES;
    localparam int WORDS        = REGION_BYTES / WORD_BYTES;
    localparam int IDX_W        = (WORDS > 1) ? $clog2(WORDS) : 1;

    phase_e      state_q, state_d;
    test_cfg_t   cfg_q;
    logic        fail_q;

    logic              accept;
    logic              acc_done;
    logic              mismatch;
    logic              walk_adv;
    logic [ADDR_W-1:0] region_off;
    logic              walk_none;
    logic              walk_last;
    logic [IDX_W-1:0]  word_idx;
    logic              word_last;
    logic [ADDR_W-1:0] word_addr;
    logic [31:0]       expect_word;

    assign accept   = (state_q == ST_IDLE) && start;
    assign acc_done = mem_req && mem_ack;
    assign mismatch = (state_q == ST_READ) && acc_done && (mem_rdata != expect_word);
    assign walk_adv = (state_q == ST_READ) && acc_done && !mismatch
                      && word_last && !walk_last;

    rdly_region_walk #(
        .ADDR_W      (ADDR_W),
        .REGION_BYTES(REGION_BYTES)
    ) i_walk (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .advance (walk_adv),
        .size_i  (mem_size),
        .offset_o(region_off),
        .none_o  (walk_none),
        .last_o  (walk_last)
    );

    rdly_word_seq #(
        .WORDS(WORDS)
    ) i_seq (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (acc_done),
        .idx_o (word_idx),
        .last_o(word_last)
    );

    rdly_pattern #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) i_pat (
        .offset_i(region_off),
        .idx_i   (word_idx),
        .bias_i  (cfg_q.bias),
        .addr_o  (word_addr),
        .expect_o(expect_word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SAFE;
            ST_SAFE: state_d = walk_none ? ST_DONE : ST_FILL;
            ST_FILL: if (acc_done && word_last) state_d = ST_PATT;
            ST_PATT: if (acc_done && word_last) state_d = ST_CAND;
            ST_CAND: state_d = ST_READ;
            ST_READ: begin
                if (mismatch) begin
                    state_d = ST_DONE;
                end else if (acc_done && word_last) begin
                    state_d = walk_last ? ST_DONE : ST_SAFE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cfg_q.cand <= cand_dly;
                cfg_q.bias <= bias;
                fail_q     <= 1'b0;
            end else if (mismatch) begin
                fail_q <= 1'b1;
            end
        end
    end

    always_comb begin
        mem_req   = (state_q == ST_FILL) || (state_q == ST_PATT) || (state_q == ST_READ);
        mem_we    = (state_q == ST_FILL) || (state_q == ST_PATT);
        mem_addr  = word_addr;
        mem_wdata = (state_q == ST_FILL) ? FILL_WORD : expect_word;
        dly_we    = ((state_q == ST_SAFE) && !walk_none) || (state_q == ST_CAND);
        dly_wdata = (state_q == ST_CAND) ? cfg_q.cand : SAFE_DLY;
        done      = (state_q == ST_DONE);
        fail      = fail_q;
    end
endmodule

// File: rtl/rdly_checker.sv
module rdly_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              fail,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              dly_we
);
    // R11
    req_dly_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && dly_we));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R4
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fail != $past(fail)) |-> (done || $past(start)));

    // R2
    dly_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        dly_we |=> !dly_we);
endmodule

bind rdly_pattern_tester rdly_checker #(.ADDR_W(ADDR_W)) i_rdly_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .done     (done),
    .fail     (fail),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .dly_we   (dly_we)
);

// File: tb/test_rdly_pattern_tester.sv
`timescale 1ns/1ps
module test_rdly_pattern_tester;
    localparam int AW       = 16;
    localparam int RWORDS   = 4;
    localparam logic [31:0] SAFE = 32'h0000_7474;
    localparam logic [31:0] FILL = 32'h1F1F_1F1F;

    typedef struct packed {
        logic [15:0] size;
        logic [31:0] cand;
        logic [31:0] bias;
        logic [15:0] flt;
        logic        efail;
        logic [7:0]  eregions;
        logic [15:0] ereads;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd256,  32'h0000_5A6B, 32'd3,        16'hFFFF, 1'b0, 8'd60, 16'd240},
        '{16'd512,  32'h0000_1234, 32'd1,        16'hFFFF, 1'b0, 8'd62, 16'd248},
        '{16'd1024, 32'h0000_7777, 32'd3,        16'hFFFF, 1'b0, 8'd63, 16'd252},
        '{16'd256,  32'h0000_0F0F, 32'd1,        16'd8,    1'b1, 8'd1,  16'd3},
        '{16'd256,  32'h0000_2222, 32'd3,        16'd64,   1'b1, 8'd14, 16'd56},
        '{16'd1024, 32'h0000_3333, 32'd1,        16'd1004, 1'b1, 8'd63, 16'd252},
        '{16'd1024, 32'h0000_4444, 32'd3,        16'd1020, 1'b0, 8'd63, 16'd252},
        '{16'd16,   32'h0000_5555, 32'd3,        16'hFFFF, 1'b0, 8'd0,  16'd0},
        '{16'd20,   32'h0000_6666, 32'd1,        16'hFFFF, 1'b0, 8'd1,  16'd4},
        '{16'd256,  32'h0000_1111, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, 8'd60, 16'd240}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [31:0]   cand_dly = '0;
    logic [31:0]   bias = '0;
    logic [AW-1:0] mem_size = '0;
    logic          done, fail, mem_req, mem_we, dly_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, dly_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;

    always #4 clk = ~clk;

    rdly_pattern_tester #(.ADDR_W(AW), .LINE_BYTES(4), .LINES(4)) i_rdly_pattern_tester (
        .clk(clk), .rst(rst), .start(start), .cand_dly(cand_dly), .bias(bias),
        .mem_size(mem_size), .done(done), .fail(fail), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dly_we(dly_we), .dly_wdata(dly_wdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] mem [256];
    logic [31:0] cur_dly = '0;
    logic [31:0] run_cand = '0;
    logic [31:0] run_bias = '0;
    logic [15:0] run_flt = 16'hFFFF;
    logic [15:0] run_stride = '0;
    int mon_regions, mon_cnt, n_reads, n_fill, n_patt, seq_bad, dly_bad;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory and delay-register model, evaluated away from the active edge
    always @(negedge clk) begin
        if (dly_we) begin
            cur_dly = dly_wdata;
            if (dly_wdata == SAFE) begin
                mon_regions++;
                mon_cnt = 0;
            end else if (dly_wdata != run_cand || mon_cnt != 8) begin
                dly_bad++;
            end
        end
        if (mem_req && !mem_ack) begin
            logic [15:0] eoff, eaddr;
            logic [31:0] epat;
            eoff  = 16'(mon_regions - 1) * run_stride;
            eaddr = eoff + 16'((mon_cnt % RWORDS) * 4);
            epat  = 32'(mem_addr) + 32'(mon_cnt % RWORDS) + run_bias;
            if (mon_regions == 0 || mem_addr != eaddr) seq_bad++;
            if (mem_we) begin
                if (cur_dly != SAFE) dly_bad++;
                if (mon_cnt < 4) begin
                    n_fill++;
                    if (mem_wdata != FILL) seq_bad++;
                end else if (mon_cnt < 8) begin
                    n_patt++;
                    if (mem_wdata != epat) seq_bad++;
                end else begin
                    seq_bad++;
                end
                mem[mem_addr[9:2]] = mem_wdata;
            end else begin
                n_reads++;
                if (mon_cnt < 8) seq_bad++;
                if (cur_dly != run_cand) dly_bad++;
                mem_rdata = mem[mem_addr[9:2]] ^
                            ((mem_addr == run_flt && cur_dly != SAFE) ? 32'h1 : 32'h0);
            end
            mon_cnt++;
            mem_ack = 1'b1;
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic run_vec(input vec_t v, input bit poke);
        int cyc;
        mon_regions = 0; mon_cnt = 0; n_reads = 0; n_fill = 0; n_patt = 0;
        seq_bad = 0; dly_bad = 0;
        run_cand = v.cand; run_bias = v.bias; run_flt = v.flt;
        run_stride = v.size >> 6;
        @(negedge clk);
        cand_dly = v.cand; bias = v.bias; mem_size = v.size; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(fail == 1'b0, "R9 fail cleared by start", fail, 0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (poke && cyc == 30) begin
                cand_dly = ~v.cand; bias = 32'h55; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R8 done reached", done, 1);
        chk(fail == v.efail, v.efail ? "R7 fail on mismatch" : "R8 pass result", fail, v.efail);
        chk(n_reads == v.ereads, "R7 read count", n_reads, v.ereads);
        chk(mon_regions == v.eregions, "R3 regions tested", mon_regions, v.eregions);
        chk(n_fill == RWORDS * v.eregions && n_patt == RWORDS * v.eregions,
            "R5 fill and pattern write counts", n_fill + n_patt, 2 * RWORDS * v.eregions);
        chk(seq_bad == 0, "R4 R5 address order and write data", seq_bad, 0);
        chk(dly_bad == 0, poke ? "R10 delay unaffected by busy start" : "R2 R6 delay in force",
            dly_bad, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        chk(fail == v.efail, "R9 fail held", fail, v.efail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(done == 0 && fail == 0 && mem_req == 0 && dly_we == 0, "R1 reset state",
            {done, fail, mem_req, dly_we}, 0);
        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], 1'b0);
        end
        // R9: fail stays set while idle after a failing test
        run_vec(VECS[3], 1'b0);
        repeat (5) @(negedge clk);
        chk(fail == 1'b1, "R9 fail held while idle", fail, 1);
        // R9: next start clears it (checked inside run), R10: start while busy ignored
        run_vec(VECS[0], 1'b1);
        // R11: nothing moves while idle
        repeat (3) @(negedge clk);
        chk(mem_req == 0 && dly_we == 0, "R11 idle quiet", {mem_req, dly_we}, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule